// File: doc/BRIEF.md
# Super I/O Configuration Space Controller

This block is the configuration front end of a legacy PC Super I/O device on an 8-bit I/O bus. Software reaches it through two ports: an index port that selects a register and a data port that reads or writes it. After reset the block is locked. It opens only when a four-byte key is written to the index port in the correct order. While it is open, registers at indices 0x30 and above are banked by a logical-device number, and a fixed exit command locks it again.

Two banked registers are implemented. The first is a power-management event status register in logical device 4. Its bits are sticky: hardware pulses set them and software clears them by writing 1. The second is a flash chip-select control register in logical device 7. Its bit 0 drives a pin that steers the boot fetch to either the primary or the backup flash device.

The unlock logic is a five-state machine: `KEY_IDLE`, `KEY_B1`, `KEY_B2`, `KEY_B3` and `CFG_OPEN`. The transitions are:
- advance: a correct key byte moves the machine to the next key state.
- mismatch: any other byte written to the index port while locked goes back to `KEY_IDLE`.
- open: the fourth correct byte goes from `KEY_B3` to `CFG_OPEN`.
- exit: the exit command goes from `CFG_OPEN` back to `KEY_IDLE`.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: The index port is at I/O address 0x2E and the data port is at 0x2F. Writes to any other address have no effect, and reads of any other address return 0xFF.
- R2: The block opens only after the bytes 0x87, 0x01, 0x55, 0x55 are written to the index port in that order. It is open from the clock edge that captures the fourth byte.
- R3: While locked, any index-port write that is not the expected next key byte returns the key matcher to its start. This includes a 0x87 that arrives out of place. Data-port writes and reads neither advance nor reset the key matcher.
- R4: While locked, data-port writes change no register, index-port writes do not load the index, and every read returns 0xFF.
- R5: While open, writing 0x02 to the data port when the index is 0x02 locks the block and clears the index to 0x00. Any other value written at index 0x02 does nothing.
- R6: Writing a value to the data port at index 0x07 selects the logical device. Reading index 0x07 returns that value. Indices 0x00 to 0x2F are global and ignore the device number. The device number is kept across lock and unlock.
- R7: Index 0xF1 of logical device 4 is the event status register. Bit 0 is the infrared receiver event, bit 1 is ring indicator 1, bit 2 is ring indicator 2, bit 3 is the keyboard event and bit 4 is the mouse event. Bits 7:5 read 0 and the reset value is 0x00. A one-cycle pulse on `evt_pulse[i]` sets bit i at the next edge, even while the block is locked, and the bit stays set.
- R8: Writing 1 to a bit of the event status register clears it, and writing 0 leaves it unchanged. A pulse in the same cycle as a clear sets the bit.
- R9: Index 0xEF of logical device 7 is the chip-select register. It resets to 0x00 and all 8 bits read back as last written. `flash_sel_backup` equals its bit 0 from the edge that captures the write: 1 selects the backup device.
- R10: While open, a read of the index port returns the current index. A data-port read of an unimplemented index, or of a banked index under a different logical device, returns 0xFF.
- R11: Read data is combinational: it is valid in the same cycle that `io_rd` is high and is 0xFF whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data (0xFF when no valid read) |
| evt_pulse | input | 5 | Event pulses: {mouse, keyboard, ring 2, ring 1, infrared} |
| flash_sel_backup | output | 1 | 1 selects the backup flash device |

## Verification
The bench attacks the key matcher with these cases:
- A misplaced 0x87 in the third position. A matcher that restarts at `KEY_B1` on that byte would open early.
- A third byte of 0x00. This must not be accepted.
- A data-port write in the middle of the key. A matcher that reset on it would stay locked.

It writes a non-exit value at index 0x02, issues the real exit command, and then re-enters. An implementation that did not clear the index, or that forgot the device number, would return wrong values afterwards. It clears event bits in the same cycle as new pulses, where a clear-wins priority would lose an event. It also reads the banked indices under the wrong device, where a design without banking would leak the other register. A long random phase with biased addresses and keys runs against the same reference model.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [2:0] {
        KEY_IDLE,
        KEY_B1,
        KEY_B2,
        KEY_B3,
        CFG_OPEN
    } key_state_t;

    localparam logic [7:0] KEY_BYTE0 = 8'h87;
    localparam logic [7:0] KEY_BYTE1 = 8'h01;
    localparam logic [7:0] KEY_BYTE2 = 8'h55;
    localparam logic [7:0] KEY_BYTE3 = 8'h55;

    localparam logic [7:0] IDX_LDN   = 8'h07;
    localparam logic [7:0] IDX_EXIT  = 8'h02;
    localparam logic [7:0] EXIT_CODE = 8'h02;
    localparam logic [7:0] IDX_EVT   = 8'hF1;
    localparam logic [7:0] IDX_CS    = 8'hEF;
    localparam logic [7:0] LDN_EVT   = 8'h04;
    localparam logic [7:0] LDN_CS    = 8'h07;
    localparam logic [7:0] RD_EMPTY  = 8'hFF;

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    input  logic       exit_req,
    output logic       unlocked
);

    key_state_t state_q, state_d;
    logic [7:0] exp_byte;

    // Byte the matcher expects next in each locked state
    always_comb begin
        exp_byte = KEY_BYTE0;
        unique case (state_q)
            KEY_IDLE: exp_byte = KEY_BYTE0;
            KEY_B1:   exp_byte = KEY_BYTE1;
            KEY_B2:   exp_byte = KEY_BYTE2;
            KEY_B3:   exp_byte = KEY_BYTE3;
            CFG_OPEN: exp_byte = KEY_BYTE0;
            default:  exp_byte = KEY_BYTE0;
        endcase
    end

    // Next-state logic: advance, mismatch, open, exit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: if (idx_wr) state_d = (wdata == exp_byte) ? KEY_B1   : KEY_IDLE;
            KEY_B1:   if (idx_wr) state_d = (wdata == exp_byte) ? KEY_B2   : KEY_IDLE;
            KEY_B2:   if (idx_wr) state_d = (wdata == exp_byte) ? KEY_B3   : KEY_IDLE;
            KEY_B3:   if (idx_wr) state_d = (wdata == exp_byte) ? CFG_OPEN : KEY_IDLE;
            CFG_OPEN: if (exit_req) state_d = KEY_IDLE;
            default:  state_d = KEY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unlocked = (state_q == CFG_OPEN);
    end

    AST_KEY_MISMATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CFG_OPEN && idx_wr && wdata != exp_byte) |=> (state_q == KEY_IDLE)); // R3
    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KEY_B3 && idx_wr && wdata == 8'h55) |=> unlocked); // R2
    AST_EXIT_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && exit_req) |=> !unlocked); // R5
    AST_NO_DATA_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && !idx_wr) |=> $stable(state_q)); // R3

endmodule

// File: rtl/sio_evt_reg.sv
module sio_evt_reg #(
    parameter int NUM_EVT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] pulse,
    input  logic               clr_wr,
    input  logic [NUM_EVT-1:0] clr_mask,
    output logic [NUM_EVT-1:0] status
);

    logic [NUM_EVT-1:0] evt_q;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                evt_q[i] <= 1'b0;
            else
                evt_q[i] <= pulse[i] | (evt_q[i] & ~(clr_wr & clr_mask[i]));
        end
    end

    assign status = evt_q;

    logic [NUM_EVT-1:0] keep_chk;
    assign keep_chk = clr_wr ? (status & ~clr_mask) : status;

    AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse) |=> ((status & $past(pulse)) == $past(pulse))); // R7
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|keep_chk) |=> ((status & $past(keep_chk)) == $past(keep_chk))); // R8

endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
    import sio_cfg_pkg::*;
#(
    parameter int                IO_AW      = 16,
    parameter int                NUM_EVT    = 5,
    parameter logic [IO_AW-1:0]  INDEX_ADDR = 16'h002E,
    parameter logic [IO_AW-1:0]  DATA_ADDR  = 16'h002F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unlocked,
    input  logic [IO_AW-1:0]   addr,
    input  logic [7:0]         wdata,
    input  logic               wr,
    input  logic               rd,
    input  logic [NUM_EVT-1:0] evt_status,
    output logic               idx_wr,
    output logic               exit_req,
    output logic               evt_clr_wr,
    output logic [7:0]         rdata,
    output logic               cs_bit
);

    localparam int PAD = 8 - NUM_EVT;

    logic [7:0] index_q;
    logic [7:0] ldn_q;
    logic [7:0] cs_q;
    logic       data_wr;

    always_comb begin
        idx_wr     = wr && (addr == INDEX_ADDR);
        data_wr    = wr && (addr == DATA_ADDR) && unlocked;
        exit_req   = data_wr && (index_q == IDX_EXIT) && (wdata == EXIT_CODE);
        evt_clr_wr = data_wr && (index_q == IDX_EVT) && (ldn_q == LDN_EVT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   index_q <= 8'h00;
        else if (exit_req)            index_q <= 8'h00;
        else if (idx_wr && unlocked)  index_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              ldn_q <= 8'h00;
        else if (data_wr && index_q == IDX_LDN)  ldn_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cs_q <= 8'h00;
        else if (data_wr && index_q == IDX_CS && ldn_q == LDN_CS)
            cs_q <= wdata;
    end

    assign cs_bit = cs_q[0];

    always_comb begin
        rdata = RD_EMPTY;
        if (rd && unlocked) begin
            if (addr == INDEX_ADDR) begin
                rdata = index_q;
            end else if (addr == DATA_ADDR) begin
                if (index_q == IDX_LDN)
                    rdata = ldn_q;
                else if (index_q == IDX_EVT && ldn_q == LDN_EVT)
                    rdata = {{PAD{1'b0}}, evt_status};
                else if (index_q == IDX_CS && ldn_q == LDN_CS)
                    rdata = cs_q;
            end
        end
    end

    AST_LOCKED_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked) |-> (rdata == RD_EMPTY)); // R4
    AST_LOCKED_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked) |=> $stable(cs_q)); // R4
    AST_LOCKED_LDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked) |=> $stable(ldn_q)); // R4
    AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd) |-> (rdata == RD_EMPTY)); // R11

endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
    import sio_cfg_pkg::*;
#(
    parameter int               IO_AW      = 16,
    parameter int               NUM_EVT    = 5,
    parameter logic [IO_AW-1:0] INDEX_ADDR = 16'h002E,
    parameter logic [IO_AW-1:0] DATA_ADDR  = 16'h002F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IO_AW-1:0]   io_addr,
    input  logic [7:0]         io_wdata,
    input  logic               io_wr,
    input  logic               io_rd,
    output logic [7:0]         io_rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    output logic               flash_sel_backup
);

    logic               unlocked;
    logic               idx_wr;
    logic               exit_req;
    logic               evt_clr_wr;
    logic [NUM_EVT-1:0] evt_status;
    logic               cs_bit;

    sio_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (io_wdata),
        .exit_req (exit_req),
        .unlocked (unlocked)
    );

    sio_reg_bank #(
        .IO_AW      (IO_AW),
        .NUM_EVT    (NUM_EVT),
        .INDEX_ADDR (INDEX_ADDR),
        .DATA_ADDR  (DATA_ADDR)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlocked   (unlocked),
        .addr       (io_addr),
        .wdata      (io_wdata),
        .wr         (io_wr),
        .rd         (io_rd),
        .evt_status (evt_status),
        .idx_wr     (idx_wr),
        .exit_req   (exit_req),
        .evt_clr_wr (evt_clr_wr),
        .rdata      (io_rdata),
        .cs_bit     (cs_bit)
    );

    sio_evt_reg #(
        .NUM_EVT (NUM_EVT)
    ) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse    (evt_pulse),
        .clr_wr   (evt_clr_wr),
        .clr_mask (io_wdata[NUM_EVT-1:0]),
        .status   (evt_status)
    );

    assign flash_sel_backup = cs_bit;

    AST_FLASH_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr) |=> $stable(flash_sel_backup)); // R9

endmodule

// File: tb/sio_cfg_ctrl_test.sv
`timescale 1ns/1ps
module sio_cfg_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [4:0]  evt_pulse = 5'h0;
    logic        flash_sel_backup;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sio_cfg_ctrl uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .io_addr          (io_addr),
        .io_wdata         (io_wdata),
        .io_wr            (io_wr),
        .io_rd            (io_rd),
        .io_rdata         (io_rdata),
        .evt_pulse        (evt_pulse),
        .flash_sel_backup (flash_sel_backup)
    );

    // Reference model state
    byte unsigned keyq[$] = '{8'h87, 8'h01, 8'h55, 8'h55};
    int          m_pos  = 0;
    bit          m_open = 0;
    byte unsigned m_idx = 0;
    byte unsigned m_ldn = 0;
    byte unsigned m_evt = 0;
    byte unsigned m_cs  = 0;

    function automatic byte unsigned model_read(input logic [15:0] a, input bit r);
        if (!r || !m_open) return 8'hFF;
        if (a == 16'h2E) return m_idx;
        if (a != 16'h2F) return 8'hFF;
        if (m_idx == 8'h07) return m_ldn;
        if (m_idx == 8'hF1 && m_ldn == 8'h04) return m_evt;
        if (m_idx == 8'hEF && m_ldn == 8'h07) return m_cs;
        return 8'hFF;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic [7:0] d, input bit w, input bit r,
                        input logic [4:0] ev, input string req);
        byte unsigned clrm;
        bit           was_open;
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = w; io_rd = r; evt_pulse = ev;
        #1;
        check(req, io_rdata, model_read(a, r), "read data");
        check("R9", flash_sel_backup, m_cs[0], "flash select");
        @(posedge clk);
        was_open = m_open;
        clrm = (w && a == 16'h2F && was_open && m_idx == 8'hF1 && m_ldn == 8'h04) ? (d & 8'h1F) : 8'h00;
        m_evt = (m_evt & ~clrm) | {3'b000, ev};
        if (w && a == 16'h2E) begin
            if (was_open) m_idx = d;
            else if (d == keyq[m_pos]) begin
                m_pos++;
                if (m_pos == keyq.size()) begin m_open = 1; m_pos = 0; end
            end else m_pos = 0;
        end
        if (w && a == 16'h2F && was_open) begin
            if (m_idx == 8'h07) m_ldn = d;
            else if (m_idx == 8'hEF && m_ldn == 8'h07) m_cs = d;
            else if (m_idx == 8'h02 && d == 8'h02) begin m_open = 0; m_idx = 0; end
        end
    endtask

    task automatic wr_idx(input logic [7:0] d, input string req);
        step(16'h2E, d, 1, 0, 5'h0, req);
    endtask
    task automatic wr_dat(input logic [7:0] d, input string req);
        step(16'h2F, d, 1, 0, 5'h0, req);
    endtask
    task automatic rd_port(input logic [15:0] a, input string req);
        step(a, 8'h00, 0, 1, 5'h0, req);
    endtask
    task automatic unlock(input string req);
        wr_idx(8'h87, req); wr_idx(8'h01, req); wr_idx(8'h55, req); wr_idx(8'h55, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // Reset state and locked behaviour (R4)
        rd_port(16'h2F, "R4");
        rd_port(16'h2E, "R4");
        wr_dat(8'h01, "R4");
        step(16'h2F, 8'h00, 0, 0, 5'h0, "R11");

        // Unlock (R2)
        unlock("R2");
        rd_port(16'h2E, "R10");
        step(16'h2E, 8'h00, 0, 0, 5'h0, "R11");

        // Logical device 7, chip select (R6, R9)
        wr_idx(8'h07, "R6"); wr_dat(8'h07, "R6"); rd_port(16'h2F, "R6");
        wr_idx(8'hEF, "R9"); wr_dat(8'hA5, "R9"); rd_port(16'h2F, "R9");

        // Event status in device 4 (R7, R8)
        step(16'h0000, 8'h00, 0, 0, 5'b00100, "R7");
        wr_idx(8'h07, "R6"); wr_dat(8'h04, "R6");
        wr_idx(8'hF1, "R7"); rd_port(16'h2F, "R7");
        step(16'h0000, 8'h00, 0, 0, 5'b10001, "R7");
        rd_port(16'h2F, "R7");
        wr_dat(8'h04, "R8"); rd_port(16'h2F, "R8");
        step(16'h2F, 8'h01, 1, 0, 5'b00001, "R8"); rd_port(16'h2F, "R8");
        wr_dat(8'hE0, "R8"); rd_port(16'h2F, "R8");

        // Unimplemented and wrong-device reads (R10), other addresses (R1)
        wr_idx(8'h30, "R10"); rd_port(16'h2F, "R10");
        wr_idx(8'hEF, "R10"); rd_port(16'h2F, "R10");
        rd_port(16'h0080, "R1"); rd_port(16'h012E, "R1");
        step(16'h004E, 8'h07, 1, 0, 5'h0, "R1"); rd_port(16'h2E, "R1");

        // Exit (R5)
        wr_idx(8'h02, "R5"); wr_dat(8'h03, "R5"); rd_port(16'h2E, "R5");
        wr_dat(8'h02, "R5"); rd_port(16'h2F, "R5"); rd_port(16'h2E, "R5");

        // Event while locked, then wrong keys (R3, R7)
        step(16'h0000, 8'h00, 0, 0, 5'b01000, "R7");
        wr_idx(8'h87, "R3"); wr_idx(8'h01, "R3"); wr_idx(8'h87, "R3");
        wr_idx(8'h01, "R3"); wr_idx(8'h55, "R3"); wr_idx(8'h55, "R3");
        rd_port(16'h2E, "R3");
        wr_idx(8'h87, "R3"); wr_idx(8'h01, "R3"); wr_idx(8'h55, "R3"); wr_idx(8'h00, "R3");
        rd_port(16'h2E, "R3");
        wr_idx(8'h87, "R3"); wr_dat(8'h55, "R3"); rd_port(16'h2F, "R3");
        wr_idx(8'h01, "R3"); wr_idx(8'h55, "R3"); wr_idx(8'h55, "R3");
        rd_port(16'h2E, "R5");
        wr_idx(8'h07, "R6"); rd_port(16'h2F, "R6");
        wr_idx(8'hF1, "R7"); rd_port(16'h2F, "R7");

        // Chip select back to primary (R9)
        wr_idx(8'h07, "R9"); wr_dat(8'h07, "R9");
        wr_idx(8'hEF, "R9"); wr_dat(8'h00, "R9"); rd_port(16'h2F, "R9");
        wr_dat(8'h01, "R9"); rd_port(16'h2F, "R9");

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int          sel;
            sel = $urandom_range(0, 9);
            a = (sel < 5) ? 16'h2E : (sel < 9) ? 16'h2F : 16'($urandom_range(0, 255));
            case ($urandom_range(0, 7))
                0: d = 8'h87;
                1: d = 8'h01;
                2: d = 8'h55;
                3: d = 8'h02;
                4: d = 8'h07;
                5: d = ($urandom_range(0, 1) != 0) ? 8'hF1 : 8'hEF;
                6: d = ($urandom_range(0, 1) != 0) ? 8'h04 : 8'h07;
                default: d = 8'($urandom_range(0, 255));
            endcase
            step(a, d, ($urandom_range(0, 1) != 0), ($urandom_range(0, 1) != 0),
                 (($urandom_range(0, 7) == 0) ? 5'($urandom_range(0, 31)) : 5'h0), "R11");
        end

        @(negedge clk);
        io_wr = 0; io_rd = 0; evt_pulse = 0;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule